// File: doc/BRIEF.md
# Eight-Input Priority Interrupt Controller

The block gathers eight interrupt request lines and raises a single interrupt toward a processor. The processor reaches it through a byte-wide port with one address bit: address 0 is the command port and address 1 is the data port. Before anything can be serviced, software must program the block with a sequence of two to four setup words. The first word chooses the trigger mode (level or edge). It also says whether a cascade word and a mode word will follow.

Once setup is complete, the data port holds an 8-bit mask. Command-port writes select which status byte a command-port read returns, or they retire an in-service interrupt. Input 0 has the highest priority and the order is fixed. When the processor raises the acknowledge line, the block marks the winning input as in service and returns a vector. The vector is the programmed base, with its low three bits replaced by the input number. In automatic mode the in-service mark is removed when the acknowledge ends. In manual mode a command write removes it.

Top module: `pic_core`

## Requirements
- R1: After reset the interrupt output is low. A data-port read returns 0xFF. A command-port read returns 0x00 (the pending-request byte).
- R2: A command-port write with data bit 4 set starts setup and clears the in-service and pending state. The next data-port write is the base word, and bits 7:3 become the vector base. If bit 1 of the first word was 0, one cascade word follows. If bit 0 of the first word was 1, one mode word follows. Until the last expected word is written, the interrupt output stays low and data-port reads return 0xFF.
- R3: Bit 1 of the mode word set selects automatic end-of-interrupt. When the mode word is skipped, or its bit 1 is 0, the end-of-interrupt is manual.
- R4: After setup, a data-port write loads the mask and a data-port read returns it. A mask bit of 1 keeps that input from raising the interrupt. Setup leaves the mask at 0x00.
- R5: With bit 3 of the first word set (level mode), a request is pending in the cycle after its input goes high. It stays pending only while the input stays high.
- R6: With bit 3 of the first word clear (edge mode), a rising input edge latches a pending request. The request stays latched after the input falls. The acknowledge that services it clears it.
- R7: The interrupt output is high whenever an unmasked pending input has a smaller number than every input that is in service. Among such inputs, the smallest number wins.
- R8: From the cycle after the acknowledge rises, and for as long as it stays high, the vector output is the base in bits 7:3 and the winning input number in bits 2:0.
- R9: The rising edge of the acknowledge sets the in-service bit of the winner. In automatic mode, the falling edge of the acknowledge clears that bit.
- R10: A command-port write with bit 4 = 0 and bit 3 = 1 is a read-select command. If bits 1:0 are 10, later command-port reads return the pending-request byte. If bits 1:0 are 11, they return the in-service byte. Any other value in bits 1:0 leaves the selection unchanged.
- R11: A command-port write with bits 7:5 = 001 and bits 4:3 = 00 clears the in-service bit with the smallest number. If it falls in the same cycle as an acknowledge rise, it acts on the in-service bits as they were before that acknowledge.
- R12: An acknowledge that finds no eligible input returns input number 7 in the vector and leaves the in-service byte unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 1 | 0 selects the command port, 1 selects the data port |
| wr_i | input | 1 | Write strobe, one cycle per byte |
| rd_i | input | 1 | Read strobe; data_o is updated in the following cycle |
| data_i | input | 8 | Write data |
| data_o | output | 8 | Read data |
| irq_req_i | input | 8 | Interrupt request lines, input 0 has the highest priority |
| int_o | output | 1 | Interrupt request to the processor |
| inta_i | input | 1 | Interrupt acknowledge from the processor |
| vector_o | output | 8 | Vector of the current acknowledge |

## Verification
An end-of-interrupt command and a new acknowledge can land in the same clock cycle. That cycle both clears the lowest-numbered in-service bit and sets the bit of the new winner. The bench runs in manual mode with input 4 in service and input 1 pending. It drives the command write and the acknowledge rise on the same edge. The result is judged by the vector (which must name input 1) and by an in-service read of exactly 0x02, which shows that the clear used the bits from before the acknowledge.

// File: rtl/pic_pkg.sv
package pic_pkg;
  localparam int unsigned DATA_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_BASE,
    ST_CASC,
    ST_MODE,
    ST_READY
  } init_st_e;
endpackage

// File: rtl/pic_cfg.sv
module pic_cfg
  import pic_pkg::*;
#(
  parameter int unsigned N_IRQ = 8,
  localparam int unsigned IW = $clog2(N_IRQ)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                addr_i,
  input  logic                wr_i,
  input  logic [DATA_W-1:0]   data_i,
  output logic                ready_o,
  output logic                level_o,
  output logic                aeoi_o,
  output logic [DATA_W-IW-1:0] base_o,
  output logic [N_IRQ-1:0]    mask_o,
  output logic                sel_isr_o,
  output logic                restart_o,
  output logic                eoi_o
);
  init_st_e st_q;
  logic single_q, need_mode_q;
  logic [N_IRQ-1:0] mask_q;

  assign restart_o = wr_i && !addr_i && data_i[4];
  assign ready_o   = (st_q == ST_READY);
  assign mask_o    = ready_o ? mask_q : '1;
  assign eoi_o     = wr_i && !addr_i && ready_o &&
                     (data_i[7:5] == 3'b001) && (data_i[4:3] == 2'b00);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q        <= ST_IDLE;
      level_o     <= 1'b0;
      single_q    <= 1'b0;
      need_mode_q <= 1'b0;
      aeoi_o      <= 1'b0;
      base_o      <= '0;
      mask_q      <= '1;
      sel_isr_o   <= 1'b0;
    end else if (restart_o) begin
      st_q        <= ST_BASE;
      level_o     <= data_i[3];
      single_q    <= data_i[1];
      need_mode_q <= data_i[0];
      aeoi_o      <= 1'b0;
      mask_q      <= '0;
      sel_isr_o   <= 1'b0;
    end else if (wr_i && addr_i) begin
      unique case (st_q)
        ST_BASE: begin
          base_o <= data_i[DATA_W-1:IW];
          st_q   <= !single_q ? ST_CASC : (need_mode_q ? ST_MODE : ST_READY);
        end
        ST_CASC:  st_q <= need_mode_q ? ST_MODE : ST_READY;
        ST_MODE: begin
          aeoi_o <= data_i[1];
          st_q   <= ST_READY;
        end
        ST_READY: mask_q <= data_i[N_IRQ-1:0];
        default: ;
      endcase
    end else if (wr_i && ready_o && data_i[3] && data_i[1]) begin
      sel_isr_o <= data_i[0];
    end
  end

  p_mask_locked_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ready_o |-> (mask_o == '1));
  p_setup_exit_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_IDLE) && !restart_o |=> (st_q == ST_IDLE));
endmodule

// File: rtl/pic_req.sv
module pic_req #(
  parameter int unsigned N_IRQ = 8,
  localparam int unsigned IW = $clog2(N_IRQ)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             restart_i,
  input  logic             level_i,
  input  logic [N_IRQ-1:0] req_i,
  input  logic             ack_i,
  input  logic [IW-1:0]    ack_idx_i,
  output logic [N_IRQ-1:0] irr_o
);
  logic [N_IRQ-1:0] req_q, irr_q, clr;

  assign clr   = ack_i ? (N_IRQ'(1) << ack_idx_i) : '0;
  assign irr_o = irr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q <= '0;
      irr_q <= '0;
    end else begin
      req_q <= req_i;
      if (restart_i)    irr_q <= '0;
      else if (level_i) irr_q <= req_i;
      else              irr_q <= (irr_q & ~clr) | (req_i & ~req_q);  // new edge beats clear
    end
  end

  for (genvar g = 0; g < N_IRQ; g++) begin : g_chk
    p_edge_needs_rise_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!level_i && !req_i[g] && !irr_q[g]) |=> !irr_q[g]);
  end
endmodule

// File: rtl/pic_prio.sv
module pic_prio
  import pic_pkg::*;
#(
  parameter int unsigned N_IRQ = 8,
  localparam int unsigned IW = $clog2(N_IRQ)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                restart_i,
  input  logic                ready_i,
  input  logic                aeoi_i,
  input  logic                eoi_i,
  input  logic [N_IRQ-1:0]    irr_i,
  input  logic [N_IRQ-1:0]    mask_i,
  input  logic [DATA_W-IW-1:0] base_i,
  input  logic                inta_i,
  output logic                int_o,
  output logic                ack_o,
  output logic [IW-1:0]       ack_idx_o,
  output logic [DATA_W-1:0]   vector_o,
  output logic [N_IRQ-1:0]    isr_o
);
  logic [N_IRQ-1:0] isr_q, elig, low_isr, isr_d;
  logic [IW-1:0]    win, vidx_q;
  logic             inta_q, hit_q, any, ack_rise, ack_fall;

  always_comb begin
    logic blk;
    blk  = 1'b0;
    elig = '0;
    for (int i = 0; i < N_IRQ; i++) begin
      blk     = blk | isr_q[i];
      elig[i] = irr_i[i] & ~mask_i[i] & ~blk;
    end
    win = '0;
    for (int i = N_IRQ - 1; i >= 0; i--) if (elig[i]) win = IW'(i);
  end

  assign any       = ready_i && (elig != '0);
  assign int_o     = any;
  assign ack_rise  = inta_i && !inta_q;
  assign ack_fall  = !inta_i && inta_q;
  assign ack_o     = ack_rise && any;
  assign ack_idx_o = win;
  assign low_isr   = isr_q & (~isr_q + 1'b1);
  assign vector_o  = {base_i, vidx_q};
  assign isr_o     = isr_q;

  always_comb begin
    isr_d = isr_q & ~(eoi_i ? low_isr : '0);  // EOI sees pre-ack state
    if (ack_o) isr_d = isr_d | (N_IRQ'(1) << win);
    if (ack_fall && aeoi_i && hit_q) isr_d = isr_d & ~(N_IRQ'(1) << vidx_q);
    if (restart_i) isr_d = '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      isr_q  <= '0;
      inta_q <= 1'b0;
      vidx_q <= '0;
      hit_q  <= 1'b0;
    end else begin
      isr_q  <= isr_d;
      inta_q <= inta_i;
      if (ack_rise) begin
        vidx_q <= any ? win : IW'(N_IRQ - 1);
        hit_q  <= any;
      end
    end
  end

  p_int_gated_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ready_i |-> !int_o);
  p_ack_sets_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o && !restart_i |=> isr_q[$past(win)]);
  p_auto_single_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    aeoi_i |-> $onehot0(isr_q));
  p_eoi_clears_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eoi_i && isr_q != '0 && !ack_o && !restart_i) |=>
      ($countones(isr_q) < $past($countones(isr_q))));
  p_spurious_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_rise && !any && !eoi_i && !restart_i && !(ack_fall && aeoi_i)) |=> $stable(isr_q));
endmodule

// File: rtl/pic_core.sv
module pic_core
  import pic_pkg::*;
#(
  parameter int unsigned N_IRQ = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              addr_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W-1:0] data_o,
  input  logic [N_IRQ-1:0]  irq_req_i,
  output logic              int_o,
  input  logic              inta_i,
  output logic [DATA_W-1:0] vector_o
);
  localparam int unsigned IW = $clog2(N_IRQ);

  logic ready, level, aeoi, sel_isr, restart, eoi, ack;
  logic [DATA_W-IW-1:0] base;
  logic [N_IRQ-1:0] mask, irr, isr;
  logic [IW-1:0] ack_idx;

  pic_cfg #(.N_IRQ(N_IRQ)) u_cfg (
    .clk_i, .rst_ni, .addr_i, .wr_i, .data_i,
    .ready_o(ready), .level_o(level), .aeoi_o(aeoi), .base_o(base),
    .mask_o(mask), .sel_isr_o(sel_isr), .restart_o(restart), .eoi_o(eoi)
  );

  pic_req #(.N_IRQ(N_IRQ)) u_req (
    .clk_i, .rst_ni, .restart_i(restart), .level_i(level),
    .req_i(irq_req_i), .ack_i(ack), .ack_idx_i(ack_idx), .irr_o(irr)
  );

  pic_prio #(.N_IRQ(N_IRQ)) u_prio (
    .clk_i, .rst_ni, .restart_i(restart), .ready_i(ready), .aeoi_i(aeoi),
    .eoi_i(eoi), .irr_i(irr), .mask_i(mask), .base_i(base), .inta_i,
    .int_o, .ack_o(ack), .ack_idx_o(ack_idx), .vector_o, .isr_o(isr)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   data_o <= '0;
    else if (rd_i) data_o <= addr_i ? DATA_W'(mask) : DATA_W'(sel_isr ? isr : irr);
  end

  p_read_mask_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && addr_i && !ready) |=> (data_o == '1));
endmodule

// File: tb/tb_pic_core.sv
module tb_pic_core;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       addr = 1'b0, wr = 1'b0, rd = 1'b0, inta = 1'b0;
  logic [7:0] wdata = '0, rdata, req = '0, vec;
  logic       intr;
  int n_chk = 0, n_fail = 0;

  always #5 clk = ~clk;

  pic_core dut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wr_i(wr), .rd_i(rd),
    .data_i(wdata), .data_o(rdata), .irq_req_i(req), .int_o(intr),
    .inta_i(inta), .vector_o(vec)
  );

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic wr_b(logic a, logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1'b1;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic rd_b(logic a, output logic [7:0] d);
    @(negedge clk); addr = a; rd = 1'b1;
    @(negedge clk); rd = 1'b0; d = rdata;
  endtask

  task automatic ack_on;  @(negedge clk); inta = 1'b1; @(negedge clk); endtask
  task automatic ack_off; @(negedge clk); inta = 1'b0; @(negedge clk); endtask

  task automatic pulse(int i);
    @(negedge clk); req[i] = 1'b1;
    @(negedge clk); req[i] = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_reset;
    logic [7:0] d;
    chk("R1 int", 8'(intr), 8'h00);
    rd_b(1'b1, d); chk("R1 mask", d, 8'hFF);
    rd_b(1'b0, d); chk("R1 status", d, 8'h00);
  endtask

  // level, cascade, automatic EOI, base 0x20
  task automatic t_level_auto;
    logic [7:0] d;
    req[3] = 1'b1;
    wr_b(1'b0, 8'h19); wr_b(1'b1, 8'h20); wr_b(1'b1, 8'h04);
    chk("R2 int held low", 8'(intr), 8'h00);
    rd_b(1'b1, d); chk("R2 mask during setup", d, 8'hFF);
    wr_b(1'b1, 8'h03);
    chk("R2 int after setup", 8'(intr), 8'h01);
    rd_b(1'b1, d); chk("R4 mask after setup", d, 8'h00);
    wr_b(1'b1, 8'h08);
    chk("R4 masked input", 8'(intr), 8'h00);
    rd_b(1'b1, d); chk("R4 mask readback", d, 8'h08);
    wr_b(1'b1, 8'h00);
    rd_b(1'b0, d); chk("R5 level pending", d, 8'h08);
    req[5] = 1'b1;
    ack_on; chk("R7 R8 vector", vec, 8'h23);
    wr_b(1'b0, 8'h0B);
    rd_b(1'b0, d); chk("R9 R10 isr set", d, 8'h08);
    wr_b(1'b0, 8'h08);
    rd_b(1'b0, d); chk("R10 select kept", d, 8'h08);
    ack_off;
    rd_b(1'b0, d); chk("R3 R9 auto clear", d, 8'h00);
    wr_b(1'b0, 8'h0A);
    req = '0;
    rd_b(1'b0, d); chk("R5 level dropped", d, 8'h00);
  endtask

  // edge, single, no mode word (manual EOI), base 0x40
  task automatic t_edge_manual;
    logic [7:0] d;
    wr_b(1'b0, 8'h12); wr_b(1'b1, 8'h40);
    wr_b(1'b1, 8'hF0);
    rd_b(1'b1, d); chk("R2 short setup", d, 8'hF0);
    wr_b(1'b1, 8'h00);
    pulse(4);
    rd_b(1'b0, d); chk("R6 edge latched", d, 8'h10);
    chk("R6 int", 8'(intr), 8'h01);
    ack_on; chk("R8 vector", vec, 8'h44); ack_off;
    rd_b(1'b0, d); chk("R6 cleared by ack", d, 8'h00);
    wr_b(1'b0, 8'h0B);
    rd_b(1'b0, d); chk("R3 manual keeps isr", d, 8'h10);
    pulse(6);
    chk("R7 lower blocked", 8'(intr), 8'h00);
    pulse(2);
    chk("R7 higher nests", 8'(intr), 8'h01);
    ack_on; chk("R7 vector", vec, 8'h42); ack_off;
    rd_b(1'b0, d); chk("R9 nested isr", d, 8'h14);
    wr_b(1'b0, 8'h20);
    rd_b(1'b0, d); chk("R11 eoi", d, 8'h10);
    pulse(1);
    @(negedge clk); inta = 1'b1; addr = 1'b0; wdata = 8'h20; wr = 1'b1;
    @(negedge clk); wr = 1'b0;
    chk("R11 collide vector", vec, 8'h41);
    ack_off;
    rd_b(1'b0, d); chk("R11 collide isr", d, 8'h02);
    wr_b(1'b0, 8'h20);
    wr_b(1'b1, 8'hFF);
    ack_on; chk("R12 spurious vector", vec, 8'h47); ack_off;
    rd_b(1'b0, d); chk("R12 isr unchanged", d, 8'h00);
    wr_b(1'b1, 8'h00);
    chk("R7 pending 6", 8'(intr), 8'h01);
    wr_b(1'b0, 8'h13);
    chk("R2 restart int", 8'(intr), 8'h00);
    rd_b(1'b1, d); chk("R2 restart mask", d, 8'hFF);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset;
    t_level_auto;
    t_edge_manual;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule